// File: doc/BRIEF.md
# Mode-Banked Register File with Combined PC/Status Word

This block is the integer register file of a 32-bit RISC core with a 26-bit address space. Sixteen registers are visible at any moment. Which physical copy answers for a given register number depends on the two-bit processor mode. Fast-interrupt mode swaps in its own R8 to R14. Interrupt mode and supervisor mode each swap in only their own R13 and R14. User mode sees the base set.

Register 15 is not ordinary storage. It packs the word-aligned program counter together with the condition flags, the two interrupt-disable bits and the mode itself. The block has two combinational read ports and one write port that updates on the clock edge. A separate strobe advances the PC by one instruction. A flag-load input lets the execute stage update the condition codes without writing R15.

A write to R15 carries a status-write qualifier. The current mode decides which fields that write may alter. User code cannot raise its privilege or change the interrupt masks.

Top module: `banked_regfile`

## Requirements
- R1: After reset, mode is supervisor (2'b11), both interrupt-disable bits are 1, the flags are 0 and the PC field is 0, so the raw R15 word reads 32'h0C000003.
- R2: R15 bit layout is: bit 31 N, bit 30 Z, bit 29 C, bit 28 V, bit 27 IRQ disable, bit 26 FIQ disable, bits 25:2 PC word address, bits 1:0 mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor).
- R3: In fast-interrupt mode, register numbers 8 to 14 address a private bank, while 0 to 7 stay shared with the other modes.
- R4: Interrupt mode and supervisor mode each have their own private R13 and R14. Registers 0 to 12 are shared with user mode in both of these modes.
- R5: Reading register 15 on either read port returns the stored word with the PC field increased by 2 words (8 bytes), modulo 2^24. All other fields are returned as stored.
- R6: The PC-advance strobe adds one word to the PC field, wrapping from 24'hFFFFFF to 0, when R15 is not written in the same cycle.
- R7: In user mode, a status-qualified write to R15 updates N, Z, C, V and the PC, but leaves the two interrupt-disable bits and the mode unchanged.
- R8: In a privileged mode, a status-qualified write to R15 loads bits 31:26 and 1:0 from the write data. The new mode selects banks from the next cycle.
- R9: A write to R15 without the qualifier changes only the PC field, taken from write data bits 25:2.
- R10: A write to R15 takes priority over the PC-advance strobe. A flag load in the same cycle is ignored only when the R15 write is status-qualified.
- R11: The flag-load input writes {N,Z,C,V} from its four bits, MSB first, on the clock edge.
- R12: A write to registers 0 to 14 lands in the copy selected by the mode in force at that edge. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| wr_psr | input | 1 | Status-write qualifier for R15 writes |
| pc_inc | input | 1 | Advance PC by one word |
| flag_we | input | 1 | Load condition flags |
| flag_nzcv | input | 4 | New flags {N,Z,C,V} |
| r15_out | output | 32 | Raw stored R15 word |
| mode_out | output | 2 | Current processor mode |

## Verification
Some properties are checked by assertions on every cycle. User mode never changes the mode or the interrupt masks. The PC either steps by one word, loads from an R15 write, or holds. Flag loads arrive on the next edge unless a qualified R15 write overrides them. An unqualified R15 write leaves the status fields alone. The bench scenarios cover what a single-cycle property cannot see: that banked copies keep their contents across several mode switches, and that shared registers stay shared. They also cover the 8-byte read-ahead on both ports, including its wrap at the top of the address space, and the exact packed word after each kind of R15 write.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NPHYS = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_sel,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_sel,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        wr_psr,
  input  logic        pc_inc,
  input  logic        flag_we,
  input  logic [3:0]  flag_nzcv,
  output logic [31:0] r15_out,
  output logic [1:0]  mode_out
);
  localparam logic [1:0] M_USR = 2'b00;
  localparam logic [1:0] M_FIQ = 2'b01;
  localparam logic [1:0] M_IRQ = 2'b10;
  localparam logic [1:0] M_SVC = 2'b11;
  localparam int IW = $clog2(NPHYS);

  logic [31:0] bank [NPHYS];
  logic [3:0]  nzcv;
  logic        irq_dis, fiq_dis;
  logic [23:0] pc_q;
  logic [1:0]  mode_q;
  logic        wr15;

  function automatic logic [IW-1:0] phys(input logic [1:0] m, input logic [3:0] s);
    logic [IW-1:0] sx;
    sx = IW'(s);
    if (s >= 4'd8 && m == M_FIQ)       return sx + IW'(7);
    else if (s >= 4'd13 && m == M_IRQ) return sx + IW'(9);
    else if (s >= 4'd13 && m == M_SVC) return sx + IW'(11);
    else                               return sx;
  endfunction

  assign wr15     = wr_en && (wr_sel == 4'hF);
  assign r15_out  = {nzcv, irq_dis, fiq_dis, pc_q, mode_q};
  assign mode_out = mode_q;

  assign rd_a_data = (rd_a_sel == 4'hF) ? {nzcv, irq_dis, fiq_dis, pc_q + 24'd2, mode_q}
                                        : bank[phys(mode_q, rd_a_sel)];
  assign rd_b_data = (rd_b_sel == 4'hF) ? {nzcv, irq_dis, fiq_dis, pc_q + 24'd2, mode_q}
                                        : bank[phys(mode_q, rd_b_sel)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) bank[i] <= '0;
    end else if (wr_en && wr_sel != 4'hF) begin
      bank[phys(mode_q, wr_sel)] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv    <= '0;
      irq_dis <= 1'b1;
      fiq_dis <= 1'b1;
      pc_q    <= '0;
      mode_q  <= M_SVC;
    end else if (wr15) begin
      pc_q <= wr_data[25:2];
      if (wr_psr) begin
        nzcv <= wr_data[31:28];
        if (mode_q != M_USR) begin
          irq_dis <= wr_data[27];
          fiq_dis <= wr_data[26];
          mode_q  <= wr_data[1:0];
        end
      end else if (flag_we) begin
        nzcv <= flag_nzcv;
      end
    end else begin
      if (pc_inc)  pc_q <= pc_q + 24'd1;
      if (flag_we) nzcv <= flag_nzcv;
    end
  end

  AST_USER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_USR) |=> (mode_q == M_USR && irq_dis == $past(irq_dis) && fiq_dis == $past(fiq_dis))); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !wr15) |=> (pc_q == $past(pc_q) + 24'd1)); // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_inc && !wr15) |=> $stable(pc_q)); // R6
  AST_R15_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr15 |=> (pc_q == $past(wr_data[25:2]))); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !(wr15 && wr_psr)) |=> (nzcv == $past(flag_nzcv))); // R11
  AST_NOPSR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr15 && !wr_psr && !flag_we) |=> ($stable(mode_q) && $stable(nzcv) && $stable(irq_dis) && $stable(fiq_dis))); // R9
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  rd_a_sel = 0, rd_b_sel = 0, wr_sel = 0, flag_nzcv = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, r15_out;
  logic        wr_en = 0, wr_psr = 0, pc_inc = 0, flag_we = 0;
  logic [1:0]  mode_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_regfile u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; wr_psr = 0; pc_inc = 0; flag_we = 0;
  endtask

  task automatic wreg(input logic [3:0] s, input logic [31:0] d, input logic q);
    wr_en = 1; wr_sel = s; wr_data = d; wr_psr = q;
    tick();
  endtask

  task automatic rd(input logic [3:0] s, input string tag, input logic [31:0] exp);
    rd_a_sel = s; rd_b_sel = s; #1;
    chk({tag, " portA"}, rd_a_data, exp);
    chk({tag, " portB"}, rd_b_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 raw r15", r15_out, 32'h0C000003);
    chk("R1 mode", {30'd0, mode_out}, 32'd3);
    rd(4'hF, "R5 read-ahead at reset", 32'h0C00000B);
  endtask

  task automatic t_pc_inc();
    for (int i = 0; i < 3; i++) begin pc_inc = 1; tick(); end
    chk("R6 pc advance", r15_out, 32'h0C00000F);
  endtask

  task automatic t_banks();
    wreg(4'd13, 32'hAAAA0013, 0);
    wreg(4'd0,  32'hBBBB0000, 0);
    wreg(4'hF, 32'h0C000011, 1);
    chk("R8 enter fiq", {30'd0, mode_out}, 32'd1);
    chk("R2 r15 after fiq entry", r15_out, 32'h0C000011);
    wreg(4'd8,  32'hCCCC0008, 0);
    wreg(4'd13, 32'hDDDD0013, 0);
    rd(4'd0,  "R3 fiq shared r0", 32'hBBBB0000);
    rd(4'd13, "R12 fiq r13", 32'hDDDD0013);
    wreg(4'hF, 32'h0C000012, 1);
    rd(4'd13, "R4 irq r13 private", 32'h0);
    rd(4'd8,  "R3 irq sees base r8", 32'h0);
    wreg(4'd13, 32'hEEEE0013, 0);
    wreg(4'hF, 32'h0C000013, 1);
    rd(4'd13, "R4 svc r13 kept", 32'hAAAA0013);
    wreg(4'hF, 32'h0C000011, 1);
    rd(4'd13, "R3 fiq r13 kept", 32'hDDDD0013);
    rd(4'd8,  "R3 fiq r8 kept", 32'hCCCC0008);
    wreg(4'hF, 32'h0C000012, 1);
    rd(4'd13, "R4 irq r13 kept", 32'hEEEE0013);
    wreg(4'hF, 32'h00000010, 1);
    chk("R8 enter user", r15_out, 32'h00000010);
    rd(4'd13, "R4 user r13", 32'h0);
    rd(4'd8,  "R3 user r8", 32'h0);
    rd(4'd0,  "R4 user shared r0", 32'hBBBB0000);
  endtask

  task automatic t_user_protect();
    wreg(4'hF, 32'hFC000023, 1);
    chk("R7 user psr write", r15_out, 32'hF0000020);
    chk("R7 user mode held", {30'd0, mode_out}, 32'd0);
  endtask

  task automatic t_flags();
    wreg(4'hF, 32'h00000100, 0);
    chk("R9 unqualified r15 write", r15_out, 32'hF0000100);
    flag_we = 1; flag_nzcv = 4'b0101; tick();
    chk("R11 flag load", r15_out, 32'h50000100);
    flag_we = 1; flag_nzcv = 4'b1010; pc_inc = 1; tick();
    chk("R11 flag load with pc step", r15_out, 32'hA0000104);
  endtask

  task automatic t_override();
    wr_en = 1; wr_sel = 4'hF; wr_data = 32'h00000200; wr_psr = 0;
    pc_inc = 1; flag_we = 1; flag_nzcv = 4'b0011; tick();
    chk("R10 r15 beats pc step, flags applied", r15_out, 32'h30000200);
    wr_en = 1; wr_sel = 4'hF; wr_data = 32'h00000000; wr_psr = 1;
    flag_we = 1; flag_nzcv = 4'b1111; tick();
    chk("R10 qualified write beats flag load", r15_out, 32'h00000000);
  endtask

  task automatic t_wrap();
    wreg(4'hF, 32'h03FFFFFC, 0);
    rd(4'hF, "R5 read-ahead wraps", 32'h00000004);
    pc_inc = 1; tick();
    chk("R6 pc wraps", r15_out, 32'h00000000);
  endtask

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pc_inc();
    t_banks();
    t_user_protect();
    t_flags();
    t_override();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule